// File: doc/BRIEF.md
# Bidirectional Bus Parity Transceiver

This block computes parity over a data word and shares a single parity line with a bus. The line is split into three signals: a driven value, an output enable, and a sampled input. A direction control picks the mode. In transmit mode the block drives the generated parity bit onto the line. The parity is chosen so that the data word plus the parity bit hold an odd number of ones. The check output is forced to its inactive HIGH level in this mode.

In receive mode the block releases the line and reads the parity bit driven by another agent. It then reports on the check output whether the word and the received bit together hold an odd count of ones. A companion valid input tells the block whether any agent actually drives the line. When nothing drives it, the received bit is taken as LOW and a floating flag is raised.

After reset is released, a power-up hold counter keeps the line released for a set number of cycles, so that no glitch reaches the bus while the rest of the system settles. The word may be wider than nine bits. It is covered by a chain of nine-input parity stages, and each stage after the first takes the running result of the stage before it. All outputs are registered once.

Top module: `bus_parity_xcvr`

## Requirements
- R1: One clock edge after `data_i` is sampled, `parity_out_o` is HIGH when the number of HIGH bits in `data_i` is even, and LOW when it is odd.
- R2: In transmit mode (`xmit_i` LOW at the sampling edge), `chk_ok_o` is HIGH after that edge, whatever the values of `parity_in_i` and `parity_in_vld_i`.
- R3: In receive mode (`xmit_i` HIGH at the sampling edge), `chk_ok_o` is HIGH after that edge when the count of HIGH bits in `data_i` plus the received bit is odd, and LOW when that count is even.
- R4: `parity_oe_o` is HIGH after an edge only when `xmit_i` was LOW at that edge and the power-up hold had already ended. After any edge that sampled `xmit_i` HIGH, it is LOW.
- R5: After reset is released, the hold lasts `HOLD_CYCLES` clock edges. `parity_oe_o` can first go HIGH after edge number `HOLD_CYCLES`+1.
- R6: In receive mode with `parity_in_vld_i` LOW, the received bit is taken as LOW and `bus_floating_o` goes HIGH after the edge. In every other case `bus_floating_o` is LOW after the edge.
- R7: While `rst_n` is LOW, `parity_oe_o` is LOW, `parity_out_o` is LOW, `chk_ok_o` is HIGH and `bus_floating_o` is LOW.
- R8: Parity covers all `DATA_W` bits, including bits handled by later stages of the chain. A single HIGH bit at any position 0 to `DATA_W`-1 gives `parity_out_o` LOW.
- R9: Holding the top data bit (`DATA_W`-1) HIGH makes `parity_out_o` HIGH exactly when the remaining bits hold an odd count of ones. This selects even-parity generation over those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xmit_i | input | 1 | Direction: LOW transmit, HIGH receive |
| data_i | input | DATA_W | Data word to protect |
| parity_in_i | input | 1 | Value sampled from the shared parity line |
| parity_in_vld_i | input | 1 | HIGH when some agent drives the parity line |
| parity_out_o | output | 1 | Generated parity value for the line |
| parity_oe_o | output | 1 | Drive enable for the parity line |
| chk_ok_o | output | 1 | Check result; HIGH = odd total or inactive |
| bus_floating_o | output | 1 | Receive mode found the line undriven |

## Verification
The condition hardest to reach is the edge where the power-up hold expires. Only the count of cycles since reset sets the first cycle in which `parity_oe_o` may rise, and no port shows that count. The stimulus releases reset and keeps `xmit_i` LOW from the very first edge, so the enable stays LOW for exactly the hold length and then rises on the predicted cycle. Stage boundaries in the chain are reached by walking a single HIGH bit across every data position.

// File: rtl/bpx_pkg.sv
// Package: shared constants and sizing helpers for the bus parity transceiver.
// Assumes stage fan-in of nine: the first stage takes nine data bits, and each
// following stage takes eight data bits plus the previous running result.
package bpx_pkg;

    localparam int STAGE_IN = 9;

    // Number of chained stages needed for a word of w bits.
    function automatic int stage_count(input int w);
        if (w <= STAGE_IN) return 1;
        return 1 + (w - STAGE_IN + (STAGE_IN - 2)) / (STAGE_IN - 1);
    endfunction

    // Padded width covered by n chained stages.
    function automatic int padded_width(input int n);
        return STAGE_IN + (STAGE_IN - 1) * (n - 1);
    endfunction

endpackage

// File: rtl/parity_stage9.sv
// Module: parity_stage9
// One nine-input parity cell. odd_o is HIGH when an odd number of the inputs
// are HIGH. Purely combinational; assumes the caller ties unused inputs LOW.
module parity_stage9 (
    input  logic [8:0] bits_i,
    output logic       odd_o
);

    // Reduce the nine inputs to a single odd-count flag.
    always_comb begin
        odd_o = 1'b0;
        for (int k = 0; k < 9; k++) begin
            odd_o = odd_o ^ bits_i[k];
        end
    end

endmodule

// File: rtl/parity_cascade.sv
// Module: parity_cascade
// Covers a DATA_W-bit word with a chain of nine-input stages. Stage 0 takes
// bits 8:0, and stage k takes eight further bits plus the odd flag of stage k-1.
// Assumes missing high bits are zero-padded, which does not change parity.
module parity_cascade #(
    parameter int DATA_W = 20
) (
    input  logic [DATA_W-1:0] data_i,
    output logic              word_odd_o
);
    import bpx_pkg::*;

    localparam int NSTG  = stage_count(DATA_W);
    localparam int PAD_W = padded_width(NSTG);

    logic [PAD_W-1:0] padded;
    logic [NSTG-1:0]  chain;

    // Zero-extend the word to a whole number of stages.
    always_comb padded = PAD_W'(data_i);

    parity_stage9 u_stage0 (
        .bits_i (padded[8:0]),
        .odd_o  (chain[0])
    );

    generate
        for (genvar g = 1; g < NSTG; g++) begin : g_chain
            parity_stage9 u_stage (
                .bits_i ({padded[STAGE_IN + (STAGE_IN - 1) * (g - 1) +: STAGE_IN - 1], chain[g-1]}),
                .odd_o  (chain[g])
            );
        end
    endgenerate

    // Last stage of the chain holds the result for the whole word.
    always_comb word_odd_o = chain[NSTG-1];

endmodule

// File: rtl/powerup_hold.sv
// Module: powerup_hold
// Counts HOLD_CYCLES clock edges after reset release and then raises done_o for
// good. The count saturates, so done_o stays HIGH until the next reset.
// Assumes a synchronous active-low reset.
module powerup_hold #(
    parameter int HOLD_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic done_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 1) + 1;
    localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES);

    logic [CW-1:0] cnt_q;

    // Advance the hold count until it reaches the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_q != LIMIT) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The hold has ended once the limit is reached.
    always_comb done_o = (cnt_q == LIMIT);

endmodule

// File: rtl/bus_parity_xcvr.sv
// Module: bus_parity_xcvr
// Bidirectional bus parity transceiver. The tri-state parity line is modelled
// as parity_out_o / parity_oe_o (driven by this block) and parity_in_i /
// parity_in_vld_i (what the bus carries and whether anyone drives it).
// In transmit mode (xmit_i LOW) it drives parity that makes the total odd and
// holds chk_ok_o HIGH. In receive mode it releases the line and checks for an
// odd total. All outputs are registered. Assumes a synchronous active-low reset.
module bus_parity_xcvr #(
    parameter int DATA_W      = 20,
    parameter int HOLD_CYCLES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xmit_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              parity_in_i,
    input  logic              parity_in_vld_i,
    output logic              parity_out_o,
    output logic              parity_oe_o,
    output logic              chk_ok_o,
    output logic              bus_floating_o
);

    logic word_odd;
    logic hold_done;
    logic rx_bit;
    logic floating_d;
    logic chk_ok_d;

    parity_cascade #(.DATA_W(DATA_W)) u_cascade (
        .data_i     (data_i),
        .word_odd_o (word_odd)
    );

    powerup_hold #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_o (hold_done)
    );

    // Resolve the received bit; an undriven line reads as LOW.
    always_comb begin
        rx_bit     = parity_in_vld_i & parity_in_i;
        floating_d = xmit_i & ~parity_in_vld_i;
    end

    // Check result: inactive HIGH in transmit mode, odd-total test in receive mode.
    always_comb chk_ok_d = xmit_i ? (word_odd ^ rx_bit) : 1'b1;

    // Register the line drive, enable, check and floating outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parity_out_o   <= 1'b0;
            parity_oe_o    <= 1'b0;
            chk_ok_o       <= 1'b1;
            bus_floating_o <= 1'b0;
        end else begin
            parity_out_o   <= ~word_odd;
            parity_oe_o    <= hold_done & ~xmit_i;
            chk_ok_o       <= chk_ok_d;
            bus_floating_o <= floating_d;
        end
    end

endmodule

// File: rtl/bus_parity_xcvr_chk.sv
// Module: bus_parity_xcvr_chk
// Property checker bound to bus_parity_xcvr. It keeps its own count of edges
// since reset release to check the power-up hold window.
module bus_parity_xcvr_chk #(
    parameter int DATA_W      = 20,
    parameter int HOLD_CYCLES = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xmit_i,
    input logic [DATA_W-1:0] data_i,
    input logic              parity_in_i,
    input logic              parity_in_vld_i,
    input logic              parity_out_o,
    input logic              parity_oe_o,
    input logic              chk_ok_o,
    input logic              bus_floating_o
);
    localparam int CW = $clog2(HOLD_CYCLES + 2) + 1;
    localparam logic [CW-1:0] SAT = CW'(HOLD_CYCLES + 1);

    logic [CW-1:0] edges_q;

    // Count completed edges since reset release, saturating past the hold.
    always_ff @(posedge clk) begin
        if (!rst_n) edges_q <= '0;
        else if (edges_q != SAT) edges_q <= edges_q + 1'b1;
    end

    // R1
    gen_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (parity_out_o == ~(^$past(data_i))));

    // R2
    tx_ok_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xmit_i |=> chk_ok_o);

    // R3
    rx_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xmit_i && parity_in_vld_i) |=> (chk_ok_o == ((^$past(data_i)) ^ $past(parity_in_i))));

    // R4
    rx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xmit_i |=> !parity_oe_o);

    // R5
    hold_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q <= CW'(HOLD_CYCLES)) |-> !parity_oe_o);

    // R6
    float_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xmit_i && !parity_in_vld_i) |=> bus_floating_o);

    // R6
    float_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(xmit_i && !parity_in_vld_i) |=> !bus_floating_o);

endmodule

bind bus_parity_xcvr bus_parity_xcvr_chk #(
    .DATA_W      (DATA_W),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (.*);

// File: tb/bus_parity_xcvr_bench.sv
// Scoreboard bench: the drive task pushes expected results into a queue, and
// the monitor pops and compares them shortly after each rising edge.
module bus_parity_xcvr_bench;

    localparam int DW   = 20;
    localparam int HOLD = 6;

    typedef struct {
        logic  par;
        logic  oe;
        logic  ok;
        logic  flt;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xmit = 1'b0;
    logic [DW-1:0] data = '0;
    logic          pin = 1'b0;
    logic          pvld = 1'b0;
    logic          par_o, oe_o, ok_o, flt_o;

    int   tests = 0;
    int   fails = 0;
    int   edges = 0;
    bit   done  = 1'b0;
    exp_t sb_q[$];

    always #4 clk = ~clk;

    bus_parity_xcvr #(.DATA_W(DW), .HOLD_CYCLES(HOLD)) u_bus_parity_xcvr (
        .clk            (clk),
        .rst_n          (rst_n),
        .xmit_i         (xmit),
        .data_i         (data),
        .parity_in_i    (pin),
        .parity_in_vld_i(pvld),
        .parity_out_o   (par_o),
        .parity_oe_o    (oe_o),
        .chk_ok_o       (ok_o),
        .bus_floating_o (flt_o)
    );

    // Count completed edges since reset release.
    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else edges <= edges + 1;
    end

    task automatic check(input logic act, input logic exp, input string req, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Drive one cycle of stimulus and queue its expected result.
    task automatic drive(input logic [DW-1:0] d, input logic x, input logic p,
                         input logic v, input string tag);
        exp_t e;
        int   rx;
        @(negedge clk);
        data = d; xmit = x; pin = p; pvld = v;
        rx    = (x && v && p) ? 1 : 0;
        e.par = ($countones(d) % 2) == 0;
        e.oe  = (edges >= HOLD) && !x;
        e.ok  = x ? ((($countones(d) + rx) % 2) == 1) : 1'b1;
        e.flt = x && !v;
        e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: compare outputs against the oldest queued expectation.
    always begin
        @(posedge clk);
        #2;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(par_o, e.par, e.tag, "parity_out");
            check(oe_o,  e.oe,  "R4/R5 oe", "parity_oe");
            check(ok_o,  e.ok,  "R2/R3 ok", "chk_ok");
            check(flt_o, e.flt, "R6 float", "bus_floating");
        end
    end

    initial begin
        #160000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] r;
        // R7: outputs under reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(oe_o,  1'b0, "R7", "reset oe");
        check(par_o, 1'b0, "R7", "reset parity_out");
        check(ok_o,  1'b1, "R7", "reset chk_ok");
        check(flt_o, 1'b0, "R7", "reset floating");
        rst_n = 1'b1;

        // R5: transmit from the first edge; enable must wait out the hold
        for (int i = 0; i < HOLD + 4; i++) begin
            drive(DW'($urandom), 1'b0, 1'b0, 1'b0, "R1 tx hold");
        end

        // R8: walking single HIGH bit across every stage boundary
        for (int i = 0; i < DW; i++) begin
            drive(DW'(1) << i, 1'b0, 1'b0, 1'b0, "R8 walk");
        end
        drive('0, 1'b0, 1'b0, 1'b0, "R1 zeros");
        drive('1, 1'b0, 1'b0, 1'b0, "R1 ones");

        // R2: transmit with arbitrary line contents
        for (int i = 0; i < 10; i++) begin
            drive(DW'($urandom), 1'b0, 1'($urandom), 1'($urandom), "R2 tx");
        end

        // R3: receive with matching and mismatching parity bits
        for (int i = 0; i < 40; i++) begin
            r = DW'($urandom);
            drive(r, 1'b1, (i % 3 == 0) ? 1'($urandom) : ~(^r), 1'b1, "R3 rx");
        end

        // R6: receive with nothing driving the line
        for (int i = 0; i < 8; i++) begin
            drive(DW'($urandom), 1'b1, 1'b1, 1'b0, "R6 rx float");
        end

        // R9: top bit held HIGH as even-format select
        for (int i = 0; i < 12; i++) begin
            r = DW'($urandom);
            r[DW-1] = 1'b1;
            drive(r, 1'b0, 1'b0, 1'b0, "R9 fmt");
        end

        // R4: alternate direction to check release on every receive cycle
        for (int i = 0; i < 10; i++) begin
            drive(DW'($urandom), 1'(i % 2), 1'b0, 1'b1, "R4 toggle");
        end

        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule